// File: doc/BRIEF.md
# Bidirectional Timer/Counter with Compare Match

An N-bit timer/counter (8 bits by default) that advances once per timer tick. The tick comes from a prescaler outside the block, on the `tick` input. Software configures it through four write-only registers: control, count, compare and flags. Three counting behaviours are available:

- a free-running up count that wraps;
- a clear-on-compare count whose period is set by the compare register;
- an up/down triangle count that reverses at both extremes.

A comparator checks the count against the compare register on every cycle. The timer registers each match into a compare flag on the next active tick. An overflow flag records the wrap, or the return to zero, depending on the mode. Each flag drives an interrupt request gated by its own enable bit. A flag is cleared by an interrupt acknowledge or by writing a one to its bit. The top, bottom and match strobes are exposed so that an external waveform stage can use them.

Register map, selected by `wr_addr`:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bits [2:0] clock select (0 = stopped); bits [4:3] mode; bit 5 compare interrupt enable; bit 6 overflow interrupt enable |
| 1 | Count | count value |
| 2 | Compare | compare value |
| 3 | Flags | write-one-to-clear; bit 0 overflow, bit 1 compare |

Top module: `updown_timer`

## Requirements
- R1: After reset:
  - `count` is 0 and `at_bottom` is 1;
  - both flags and both interrupt requests are 0;
  - the compare register holds 0, the mode is 00 and the clock select is 0.
- R2: While the clock select field (control bits [2:0]) is 0, ticks leave `count` unchanged.
- R3: In modes 00 and 11, each active tick increments `count`, wrapping from MAX to 0. The overflow flag sets on the tick that performs the wrap.
- R4: In mode 01, the counter counts up to MAX and then down to 0, repeating with period 2*MAX ticks. The overflow flag sets on the tick that steps from 1 to 0.
- R5: In mode 10, an active tick taken while `count` equals the compare value loads 0, giving a period of compare+1 ticks.
- R6: In every mode, an active tick taken while `count` equals the compare value sets the compare flag, so the flag appears one tick after the match begins.
- R7: A write to address 1 loads `count` in the following cycle. This load takes priority over an increment, decrement or clear in the same cycle.
- R8: A write to address 3 clears each flag whose bit is 1 (bit 0 overflow, bit 1 compare). Zero bits leave their flag unchanged.
- R9: `irq_cmp` equals the compare flag AND control bit 5, and `irq_ovf` equals the overflow flag AND control bit 6. Pulsing `irq_ack_cmp` or `irq_ack_ovf` clears the corresponding flag.
- R10: Each indicator reflects the current count:
  - `at_top` is 1 exactly when `count` is MAX;
  - `at_bottom` is 1 exactly when `count` is 0;
  - `match` is 1 exactly when `count` equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timer tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Write data; DW is the larger of CW and 7 |
| irq_ack_cmp | input | 1 | Compare interrupt acknowledge |
| irq_ack_ovf | input | 1 | Overflow interrupt acknowledge |
| count | output | CW | Current count |
| at_top | output | 1 | Count equals MAX |
| at_bottom | output | 1 | Count equals zero |
| match | output | 1 | Count equals compare value |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
The bench builds the block with CW=4, so MAX is 15. This makes every compare value reachable in the clear-on-compare sweep. A whole up/down period of 30 ticks and each wrap can be checked tick by tick against counts computed arithmetically. The short periods also keep the cycle of each flag set, and the interaction between writes and ticks, within a few cycles of observation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_UPDN = 2'b01,
    MODE_CTC  = 2'b10,
    MODE_WRAP = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CMP   = 2'd2,
    A_FLAGS = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic      ovf_ie;
    logic      cmp_ie;
    tmr_mode_e mode;
    logic [2:0] clk_sel;
  } tmr_ctrl_t;

  localparam int CTRL_W   = 7;
  localparam int N_FLAGS  = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  output tmr_ctrl_t          ctrl,
  output logic [CW-1:0]      cmp_val,
  output logic               cnt_wr,
  output logic [CW-1:0]      cnt_val,
  output logic [N_FLAGS-1:0] flag_w1c
);
  logic sel_ctrl, sel_cmp, sel_flags;

  always_comb begin
    sel_ctrl  = wr_en && (wr_addr == A_CTRL);
    sel_cmp   = wr_en && (wr_addr == A_CMP);
    sel_flags = wr_en && (wr_addr == A_FLAGS);
    cnt_wr    = wr_en && (wr_addr == A_COUNT);
    cnt_val   = wr_data[CW-1:0];
    flag_w1c  = sel_flags ? wr_data[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp_val <= '0;
    end else begin
      if (sel_ctrl) ctrl    <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (sel_cmp)  cmp_val <= wr_data[CW-1:0];
    end
  end

  // R1: configuration registers come out of reset cleared
  p_cfg_reset_r1: assert property (@(posedge clk) rst |=> (ctrl == '0 && cmp_val == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  tmr_mode_e     mode,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_val,
  output logic [CW-1:0] count,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          up_q, nxt_up, step_ovf;
  logic [CW-1:0] nxt;
  logic          at_max, at_min, hit;

  always_comb begin
    at_max   = (count == MAX);
    at_min   = (count == '0);
    hit      = (count == cmp_val);
    nxt      = count + ONE;
    nxt_up   = 1'b1;
    step_ovf = 1'b0;
    case (mode)
      MODE_UPDN: begin
        if (up_q) begin
          if (at_max) begin
            nxt    = MAX - ONE;
            nxt_up = 1'b0;
          end
        end else begin
          if (at_min) begin
            nxt    = ONE;
          end else begin
            nxt    = count - ONE;
            nxt_up = 1'b0;
          end
        end
        step_ovf = !up_q && (count == ONE);
      end
      MODE_CTC: begin
        if (hit) nxt = '0;
        step_ovf = at_max && !hit;
      end
      default: begin
        step_ovf = at_max;
      end
    endcase
    ovf_evt = run && !cnt_wr && step_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (cnt_wr) begin
      count <= cnt_val;
    end else if (run) begin
      count <= nxt;
      up_q  <= nxt_up;
    end
  end

  // R2: no tick and no write means the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> (count == $past(count)));
  // R7: register write wins over counting
  p_wr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(cnt_val)));
  // R4: reversal at the top in up/down mode
  p_updn_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr && mode == MODE_UPDN && up_q && count == MAX) |=> (count == MAX - ONE));
  // R5: clear on compare
  p_ctc_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr && mode == MODE_CTC && count == cmp_val) |=> (count == '0));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] w1c,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                    flag[i] <= 1'b0;
      else if (set[i])            flag[i] <= 1'b1;
      else if (w1c[i] || ack[i])  flag[i] <= 1'b0;
    end

    assign irq[i] = flag[i] & ie[i];

    // R6: a qualified match or overflow event sets the flag next cycle
    p_set_r6: assert property (@(posedge clk) disable iff (rst) set[i] |=> flag[i]);
    // R8: write-one or acknowledge clears when no new event arrives
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && (w1c[i] || ack[i])) |=> !flag[i]);
    // R9: otherwise the flag keeps its value
    p_keep_r9: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !w1c[i] && !ack[i]) |=> $stable(flag[i]));
  end
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import tmr_pkg::*;
#(
  parameter  int CW = 8,
  localparam int DW = (CW > CTRL_W) ? CW : CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_ack_cmp,
  input  logic          irq_ack_ovf,
  output logic [CW-1:0] count,
  output logic          at_top,
  output logic          at_bottom,
  output logic          match,
  output logic          ovf_flag,
  output logic          cmp_flag,
  output logic          irq_ovf,
  output logic          irq_cmp
);
  tmr_ctrl_t           ctrl;
  logic [CW-1:0]       cmp_val, cnt_val;
  logic                cnt_wr, run, ovf_evt;
  logic [N_FLAGS-1:0]  w1c, set, ack, ie, flag, irq;

  tmr_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .cmp_val(cmp_val), .cnt_wr(cnt_wr), .cnt_val(cnt_val), .flag_w1c(w1c)
  );

  assign run = tick && (ctrl.clk_sel != 3'd0);

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .mode(ctrl.mode), .cnt_wr(cnt_wr),
    .cnt_val(cnt_val), .cmp_val(cmp_val), .count(count), .ovf_evt(ovf_evt)
  );

  assign at_top    = (count == {CW{1'b1}});
  assign at_bottom = (count == '0);
  assign match     = (count == cmp_val);

  always_comb begin
    set           = '0;
    set[FLAG_OVF] = ovf_evt;
    set[FLAG_CMP] = run && match;
    ack           = '0;
    ack[FLAG_OVF] = irq_ack_ovf;
    ack[FLAG_CMP] = irq_ack_cmp;
    ie            = '0;
    ie[FLAG_OVF]  = ctrl.ovf_ie;
    ie[FLAG_CMP]  = ctrl.cmp_ie;
  end

  tmr_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(set), .w1c(w1c), .ack(ack), .ie(ie),
    .flag(flag), .irq(irq)
  );

  assign ovf_flag = flag[FLAG_OVF];
  assign cmp_flag = flag[FLAG_CMP];
  assign irq_ovf  = irq[FLAG_OVF];
  assign irq_cmp  = irq[FLAG_CMP];

  // R10: top and bottom never assert together
  p_top_bot_r10: assert property (@(posedge clk) disable iff (rst) !(at_top && at_bottom));
  // R9: an interrupt request implies its flag
  p_irq_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (!irq_cmp || cmp_flag) && (!irq_ovf || ovf_flag));
endmodule

// File: tb/updown_timer_tb.sv
module updown_timer_tb;
  localparam int CW  = 4;
  localparam int DW  = 7;
  localparam int MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst, tick, wr_en, irq_ack_cmp, irq_ack_ovf;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] count;
  logic          at_top, at_bottom, match, ovf_flag, cmp_flag, irq_ovf, irq_cmp;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  updown_timer #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack_cmp(irq_ack_cmp), .irq_ack_ovf(irq_ack_ovf),
    .count(count), .at_top(at_top), .at_bottom(at_bottom), .match(match),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_ack_cmp = 1'b0; irq_ack_ovf = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctl(int cs, int mode, int cie, int oie);
    return (oie << 6) | (cie << 5) | (mode << 3) | cs;
  endfunction

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 bottom", at_bottom, 1);
    chk("R1 flags", {ovf_flag, cmp_flag, irq_ovf, irq_cmp}, 0);

    // R2 stopped clock select
    wr(1, 5);
    repeat (4) one_tick();
    chk("R2 stopped", count, 5);

    // R3 modes 00 and 11
    for (int m = 0; m < 4; m += 3) begin
      do_reset();
      wr(2, 7);
      wr(0, ctl(1, m, 0, 1));
      for (int k = 1; k <= 20; k++) begin
        one_tick();
        chk("R3 count", count, k % (MAX + 1));
        chk("R3 ovf", ovf_flag, (k >= MAX + 1) ? 1 : 0);
        chk("R10 top", at_top, ((k % (MAX + 1)) == MAX) ? 1 : 0);
        chk("R10 match", match, ((k % (MAX + 1)) == 7) ? 1 : 0);
      end
      chk("R9 irq_ovf", irq_ovf, 1);
      @(negedge clk); irq_ack_ovf = 1'b1;
      @(negedge clk); irq_ack_ovf = 1'b0;
      chk("R9 ack ovf", ovf_flag, 0);
    end

    // R4 up/down
    do_reset();
    wr(2, 3);
    wr(0, ctl(2, 1, 0, 0));
    for (int k = 1; k <= 40; k++) begin
      int p, e;
      one_tick();
      p = k % (2 * MAX);
      e = (p <= MAX) ? p : 2 * MAX - p;
      chk("R4 count", count, e);
      chk("R4 ovf", ovf_flag, (k >= 2 * MAX) ? 1 : 0);
      chk("R10 bottom", at_bottom, (e == 0) ? 1 : 0);
    end

    // R5/R6 clear on compare, every compare value
    for (int c = 0; c <= MAX; c++) begin
      do_reset();
      wr(2, c);
      wr(0, ctl(1, 2, 1, 0));
      for (int k = 1; k <= 2 * (c + 1) + 1; k++) begin
        one_tick();
        chk("R5 count", count, k % (c + 1));
        chk("R6 cmp flag", cmp_flag, (k >= c + 1) ? 1 : 0);
      end
      chk("R9 irq_cmp", irq_cmp, 1);
    end

    // R7 write priority over a simultaneous tick
    do_reset();
    wr(0, ctl(1, 0, 0, 0));
    wr(1, 4);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = DW'(9);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R7 write wins", count, 9);
    one_tick();
    chk("R7 resumes", count, 10);

    // R8 write-one-to-clear, R9 acknowledge
    do_reset();
    wr(0, ctl(1, 0, 1, 0));
    one_tick();
    chk("R6 flag in normal mode", cmp_flag, 1);
    wr(3, 0);
    chk("R8 zero write keeps", cmp_flag, 1);
    wr(3, 1);
    chk("R8 ovf bit only keeps", cmp_flag, 1);
    wr(3, 2);
    chk("R8 one clears", cmp_flag, 0);
    wr(1, 0);
    one_tick();
    chk("R9 irq raised", irq_cmp, 1);
    wr(0, ctl(1, 0, 0, 0));
    chk("R9 irq masked", irq_cmp, 0);
    @(negedge clk); irq_ack_cmp = 1'b1;
    @(negedge clk); irq_ack_cmp = 1'b0;
    chk("R9 ack clears", cmp_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule